// File: doc/BRIEF.md
# Configuration Image Loader

This block moves a configuration image from a byte stream into the configuration port of a downstream programmable-logic target. A single start pulse runs a fixed sequence. The block pulses the target's reset, waits, and writes one zero byte. It waits again, then reads a 16-byte header. After that it forwards the payload and appends a short run of zero bytes. It then samples the target's error line once and finishes with either done or error.

The first four header bytes give the payload length as a big-endian 32-bit count. The other twelve header bytes are read and discarded. Three parameters set the settle times, counted in clock cycles. If the upstream stream ends early, in either the header or the payload, the load aborts with error. Upstream bytes arrive on a valid/ready handshake with an end-of-stream marker. Downstream bytes leave on a data bus with a one-cycle write strobe.

Top module: `cfg_image_loader`

## Requirements
- R1: A start pulse sampled while idle drives cfg_rst high for RESET_CYCLES cycles, beginning in the cycle after the start. SETTLE_CYCLES cycles with no activity follow. One byte of value 0 is then written.
- R2: After the zero byte, SETTLE_CYCLES idle cycles pass, and then in_ready rises to accept the header.
- R3: The header is exactly 16 accepted bytes. Bytes 0 to 3 form the payload length, most significant byte first. No header byte is ever written downstream.
- R4: Each accepted payload byte is written downstream in the same cycle it is accepted: out_wr is high and out_data equals in_data. Payload bytes keep their order, and idle input cycles produce no writes.
- R5: After the last payload byte, or directly after the header when the length is 0, exactly five bytes of value 0 are written on consecutive cycles.
- R6: cfg_err is sampled in exactly one cycle, the cycle after the last trailer write. If it is high there, error rises in the next cycle and done stays low. cfg_err at any other time has no effect.
- R7: If cfg_err is low when sampled, done rises FINAL_CYCLES+2 cycles after the last trailer write. busy falls in the same cycle, and error stays low.
- R8: If in_last arrives before the 16th header byte, the load ends with error. Nothing is written after the zero byte.
- R9: The load ends with error and no trailer if in_last comes on a payload byte before the declared count is reached. It does the same if in_last comes on header byte 15 while the length is nonzero. A zero length with in_last on byte 15 completes normally.
- R10: in_ready is low outside the header and payload phases. Bytes offered after the declared payload are not consumed.
- R11: A start while busy is ignored. done and error hold until the next start, and that start clears both.
- R12: Out of reset the block is idle, with busy, done, error, in_ready, out_wr and cfg_rst all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load when idle |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_last | input | 1 | Marks the final byte of the image stream |
| in_ready | output | 1 | Block accepts the offered byte |
| out_data | output | 8 | Byte to the configuration target |
| out_wr | output | 1 | Write strobe for out_data |
| cfg_rst | output | 1 | Reset to the configuration target |
| cfg_err | input | 1 | Error flag from the configuration target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed without error |
| error | output | 1 | Last load failed |

## Verification
The bench sweeps payload lengths from zero to twenty, with the input stream running both gap-free and with periodic idle cycles. A wrong length-byte order or a header byte leaking downstream would corrupt the write log. The bench also checks each settle window to the exact cycle, so a design off by one in a counter would move the zero byte, the header window or done.

Several streams end early: inside the header, on header byte 15 with a nonzero length, and partway through the payload. Each must give error with no trailer; a design that ignored the end marker would hang waiting for bytes. The bench also holds cfg_err high through the payload and releases it before the sample point, which catches a design that samples the flag too early. It offers bytes after the payload, which catches a design that over-consumes. Finally it pulses start in the middle of a load, which would restart a design that failed to ignore it.

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int unsigned RESET_CYCLES  = 16,
  parameter int unsigned SETTLE_CYCLES = 1000,
  parameter int unsigned FINAL_CYCLES  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_wr,
  output logic       cfg_rst,
  input  logic       cfg_err,
  output logic       busy,
  output logic       done,
  output logic       error
);
  localparam logic [31:0] HDR_LAST  = 32'd15;
  localparam logic [31:0] TRAIL_CNT = 32'd5;
  localparam logic [31:0] RST_LOAD  = 32'(RESET_CYCLES - 1);
  localparam logic [31:0] SET_LOAD  = 32'(SETTLE_CYCLES - 1);
  localparam logic [31:0] FIN_LOAD  = 32'(FINAL_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_W1, S_ZERO, S_W2, S_HDR, S_PAY, S_TRL, S_CHK, S_W3
  } state_t;

  state_t      st;
  logic [31:0] cnt;
  logic [31:0] plen;
  logic        done_q, err_q;
  logic        take;

  assign in_ready = (st == S_HDR) || (st == S_PAY);
  assign take     = in_valid && in_ready;
  assign out_wr   = (st == S_ZERO) || (st == S_TRL) || (st == S_PAY && in_valid);
  assign out_data = (st == S_PAY) ? in_data : 8'h00;
  assign cfg_rst  = (st == S_RST);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign error    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      plen   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          plen   <= '0;
          cnt    <= RST_LOAD;
          st     <= S_RST;
        end
        S_RST: if (cnt == 0) begin
          cnt <= SET_LOAD;
          st  <= S_W1;
        end else cnt <= cnt - 1;
        S_W1: if (cnt == 0) st <= S_ZERO;
              else cnt <= cnt - 1;
        S_ZERO: begin
          cnt <= SET_LOAD;
          st  <= S_W2;
        end
        S_W2: if (cnt == 0) st <= S_HDR;
              else cnt <= cnt - 1;
        S_HDR: if (take) begin
          if (cnt < 32'd4) plen <= {plen[23:0], in_data};
          if (cnt == HDR_LAST) begin
            if (plen == 0) begin
              cnt <= TRAIL_CNT - 1;
              st  <= S_TRL;
            end else if (in_last) begin
              err_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              cnt <= plen - 1;
              st  <= S_PAY;
            end
          end else if (in_last) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else cnt <= cnt + 1;
        end
        S_PAY: if (take) begin
          if (cnt == 0) begin
            cnt <= TRAIL_CNT - 1;
            st  <= S_TRL;
          end else if (in_last) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else cnt <= cnt - 1;
        end
        S_TRL: if (cnt == 0) st <= S_CHK;
               else cnt <= cnt - 1;
        S_CHK: if (cfg_err) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else begin
          cnt <= FIN_LOAD;
          st  <= S_W3;
        end
        S_W3: if (cnt == 0) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else cnt <= cnt - 1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic out_wr,
  input logic cfg_rst,
  input logic busy,
  input logic done,
  input logic error
);
  assert_rst_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rst) |-> ($past(start) && !$past(busy)));

  assert_no_write_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |-> !out_wr);

  assert_done_ends_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($fell(busy) && !error));

  assert_ready_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> busy);

  assert_done_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_error_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cfg_rst && !in_valid) |=> (busy || done || error));
endmodule

bind cfg_image_loader cfg_image_loader_chk chk_i (.*);

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;
  localparam int RST = 3, SET = 4, FIN = 6;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0, cfg_err = 0;
  logic [7:0] in_data = 0;
  wire in_ready, out_wr, cfg_rst, busy, done, error;
  wire [7:0] out_data;

  always #4 clk = ~clk;

  cfg_image_loader #(.RESET_CYCLES(RST), .SETTLE_CYCLES(SET), .FINAL_CYCLES(FIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data), .out_wr(out_wr),
    .cfg_rst(cfg_rst), .cfg_err(cfg_err), .busy(busy), .done(done), .error(error));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] img [0:63];
  logic [7:0] wlog [0:63];
  int nw, rst_cnt, rst_first, rst_last, hr_cyc, first_wr, last_wr, done_cyc, err_cyc;
  bit mon_en = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (cfg_rst) begin
        rst_cnt++;
        if (rst_first < 0) rst_first = cyc;
        rst_last = cyc;
      end
      if (in_ready && hr_cyc < 0) hr_cyc = cyc;
      if (out_wr) begin
        if (nw < 64) wlog[nw] = out_data;
        nw++;
        if (first_wr < 0) first_wr = cyc;
        last_wr = cyc;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (error && err_cyc < 0) err_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic run(input int plen, input int n, input int gap, input bit errc,
                     input bit errpay, input bit mid_start);
    int idx, st_c, guard, exp_pw, exp_nw, exp_used, bad, bad_at;
    bit short_img, exp_err;
    for (int i = 0; i < 64; i++) img[i] = 8'(i * 37 + plen * 11 + 5);
    img[0] = 8'(plen >> 24); img[1] = 8'(plen >> 16);
    img[2] = 8'(plen >> 8);  img[3] = 8'(plen);
    for (int i = 4; i < 16; i++) img[i] = 8'hA0 + 8'(i);
    short_img = (n < 16) || (n < 16 + plen);
    exp_err   = short_img || errc;
    exp_pw    = (n < 16) ? 0 : ((n - 16 < plen) ? n - 16 : plen);
    exp_nw    = 1 + exp_pw + (short_img ? 0 : 5);
    exp_used  = short_img ? n : 16 + plen;

    @(posedge clk); #1;
    start = 1; st_c = cyc + 1;
    @(posedge clk); #1;
    start = 0;
    chk(!done && !error, "R11 start clears status", {done, error}, 0);
    nw = 0; rst_cnt = 0; rst_first = -1; rst_last = -1; hr_cyc = -1;
    first_wr = -1; last_wr = -1; done_cyc = -1; err_cyc = -1; mon_en = 1;
    idx = 0; guard = 0;
    while (busy && guard < 3000) begin
      in_valid = (idx < n) && !(gap != 0 && (guard % gap) == 0);
      in_data  = img[idx < 64 ? idx : 0];
      in_last  = (idx == n - 1);
      cfg_err  = errc || (errpay && idx < 16 + plen);
      start    = mid_start && (idx == 18);
      @(negedge clk);
      if (in_valid && in_ready) idx++;
      @(posedge clk); #1;
      guard++;
    end
    in_valid = 0; in_last = 0; start = 0;
    repeat (3) @(negedge clk);
    mon_en = 0;
    cfg_err = 0;

    chk(rst_cnt == RST, "R1 reset pulse length", rst_cnt, RST);
    chk(rst_first - st_c == 1, "R1 reset follows start", rst_first - st_c, 1);
    chk(first_wr - rst_last == SET + 1, "R1 zero byte after settle", first_wr - rst_last, SET + 1);
    chk(wlog[0] == 8'h00, "R1 zero byte value", wlog[0], 0);
    chk(hr_cyc - first_wr == SET + 1, "R2 header after second settle", hr_cyc - first_wr, SET + 1);
    chk(nw == exp_nw, "R3 R5 R8 R9 write count", nw, exp_nw);
    bad = 0; bad_at = -1;
    for (int i = 0; i < exp_pw && i + 1 < 64; i++)
      if (wlog[i + 1] !== img[16 + i]) begin bad++; if (bad_at < 0) bad_at = i; end
    chk(bad == 0, "R3 R4 payload bytes in order", bad_at, -1);
    if (!short_img) begin
      bad = 0;
      for (int i = 0; i < 5; i++) if (wlog[1 + exp_pw + i] !== 8'h00) bad++;
      chk(bad == 0, "R5 trailer zeros", bad, 0);
    end
    chk(idx == exp_used, "R10 bytes consumed", idx, exp_used);
    chk(error == exp_err && done == !exp_err, "R6 R7 R8 R9 final status", {done, error}, {!exp_err, exp_err});
    if (!short_img && !errc)
      chk(done_cyc - last_wr == FIN + 2, "R7 done timing", done_cyc - last_wr, FIN + 2);
    if (!short_img && errc)
      chk(err_cyc - last_wr == 2, "R6 error timing", err_cyc - last_wr, 2);
    chk(!in_ready && !out_wr && !busy, "R10 idle quiet", {in_ready, out_wr, busy}, 0);
    repeat (10) @(negedge clk);
    chk(error == exp_err && done == !exp_err, "R11 status held", {done, error}, {!exp_err, exp_err});
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog all requirements: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !error && !in_ready && !out_wr && !cfg_rst, "R12 reset state",
        {busy, done, error, in_ready, out_wr, cfg_rst}, 0);
    foreach (img[i]) img[i] = 0;
    for (int g = 0; g < 2; g++) begin
      run(0, 16, g * 3, 0, 0, 0);
      run(1, 17, g * 3, 0, 0, 0);
      run(2, 18, g * 3, 0, 0, 0);
      run(5, 21, g * 3, 0, 0, 0);
      run(9, 25, g * 3, 0, 0, 0);
      run(20, 36, g * 3, 0, 0, 0);
    end
    run(300, 60, 0, 0, 0, 0);
    run(0, 10, 0, 0, 0, 0);
    run(0, 1, 2, 0, 0, 0);
    run(8, 19, 0, 0, 0, 0);
    run(4, 16, 0, 0, 0, 0);
    run(3, 19, 0, 1, 0, 0);
    run(6, 22, 2, 0, 1, 0);
    run(4, 29, 0, 0, 0, 0);
    run(7, 23, 0, 0, 0, 1);
    run(2, 18, 0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule